// File: doc/BRIEF.md
# Adaptive List-Position Address Bus Encoder and Decoder

This block cuts switching on a data address bus by sending, in place of each address, the positions its pieces hold in small self-organizing lists. The address is divided into equal groups of `GRP_W` bits. Each group keeps its own list of all `2^GRP_W` possible symbols. For every valid address, each group puts the current list position of its symbol on the bus and then reorders its list. Addresses that recur or alternate drift toward the low positions, so the codes they produce differ in few bits.

Two reordering rules are offered, selected by parameter. Move-to-front puts the symbol just sent at position 0. Transpose swaps it with its neighbour one place nearer the front. A further parameter turns on transition signalling, in which each code is XORed into the previous bus value. The list of a symbol is not searched: every symbol has its own position register, and all of them update in parallel. The decoder half holds an identical set of lists. It turns a received code back into the symbol holding that position and then applies the same update, so it stays in step with the encoder.

Top module: `slc_addr_codec`

## Requirements
- R1: After reset every group's list is in identity order (symbol s at position s), `enc_bus_o`, `dec_addr_o` and the previous-bus registers are zero, and both valid outputs are low.
- R2: When `enc_valid_i` is high at a clock edge, `enc_valid_o` is high after that edge and group i of `enc_bus_o` (bits i*GRP_W+GRP_W-1 down to i*GRP_W) carries the current position of the symbol in the same bits of `enc_addr_i` (transition signalling off). When `enc_valid_i` is low, `enc_valid_o` is low after the edge.
- R3: With `RULE` = 0 (move-to-front), after a symbol is sent from position k it moves to position 0, every symbol at a position below k moves down one place, and the rest keep their positions.
- R4: With `RULE` = 1 (transpose), after a symbol is sent from position k > 0 it takes position k-1 and the symbol at k-1 takes position k. Sending from position 0 leaves the list unchanged.
- R5: With `GRP_W` = 2 and a group fed 0,1,0,0,2,0,1,0,3, move-to-front emits 0,1,1,0,2,1,2,1,3 and transpose emits 0,1,1,0,2,0,2,0,3.
- R6: Each group has its own list. The codes of one group depend only on the symbol history in that group's bits, and all groups update on the same valid edge.
- R7: With `XOR_EN` = 1, each valid edge loads `enc_bus_o` with its previous value XOR the code, group by group.
- R8: While a valid input is low, the lists do not change and the matching data output (`enc_bus_o` or `dec_addr_o`) holds its value.
- R9: When `dec_valid_i` is high at an edge, `dec_valid_o` is high after it and `dec_addr_o` holds the symbols whose positions equal the received codes. The decoder lists then follow the same rule as the encoder. With the bus looped back, `dec_addr_o` reproduces the address sent.
- R10: With `XOR_EN` = 1, the decoder first XORs `dec_bus_i` with its registered copy of the previous received bus value, and updates that copy only on valid edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Address to encode is valid |
| enc_addr_i | input | ADDR_W | Address to encode |
| enc_valid_o | output | 1 | Encoded bus word valid |
| enc_bus_o | output | ADDR_W | Encoded bus word, registered |
| dec_valid_i | input | 1 | Received bus word valid |
| dec_bus_i | input | ADDR_W | Received bus word |
| dec_valid_o | output | 1 | Decoded address valid |
| dec_addr_o | output | ADDR_W | Decoded address, registered |

## Verification
Four configurations run side by side: both rules, group widths of 2, 3 and 4, and transition signalling on and off. Each has its decoder looped back to its encoder. The hardest cases are a symbol already at position 0 and the highest position. A wrong move-to-front shift range duplicates or loses a symbol, and transpose at position 0 with an unguarded neighbour compare wraps to the last position. Either fault sends codes that differ from the list model and leaves the decoder returning the wrong address. Idle cycles between valid words catch a design that updates its lists or its previous-bus copy without a valid. A mid-run reset catches a table that is not restored to identity order.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic {
    SLC_MTF       = 1'b0,
    SLC_TRANSPOSE = 1'b1
  } slc_rule_e;
endpackage

// File: rtl/slc_pos_table.sv
// Per-symbol position registers, all updated in parallel from the sent code.
module slc_pos_table #(
  parameter int                 GW   = 2,
  parameter slc_pkg::slc_rule_e RULE = slc_pkg::SLC_MTF,
  localparam int                NSYM = 1 << GW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      upd_i,
  input  logic [GW-1:0]             code_i,
  output logic [NSYM-1:0][GW-1:0]   pos_o
);
  localparam logic [GW-1:0] ONE = GW'(1);

  for (genvar s = 0; s < NSYM; s++) begin : g_sym
    logic [GW-1:0] pos_q, pos_d;

    if (RULE == slc_pkg::SLC_MTF) begin : g_mtf
      always_comb begin
        if (pos_q == code_i)     pos_d = '0;
        else if (pos_q < code_i) pos_d = pos_q + ONE;
        else                     pos_d = pos_q;
      end
    end else begin : g_tr
      always_comb begin
        if ((pos_q == code_i) && (pos_q != '0))            pos_d = pos_q - ONE;
        else if ((code_i != '0) && (pos_q == code_i - ONE)) pos_d = pos_q + ONE;
        else                                                pos_d = pos_q;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pos_q <= GW'(s);
      else if (upd_i) pos_q <= pos_d;
    end

    assign pos_o[s] = pos_q;
  end
endmodule

// File: rtl/slc_enc_group.sv
module slc_enc_group #(
  parameter int                 GW     = 2,
  parameter slc_pkg::slc_rule_e RULE   = slc_pkg::SLC_MTF,
  parameter bit                 XOR_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [GW-1:0] sym_i,
  output logic [GW-1:0] bus_o
);
  localparam int NSYM = 1 << GW;

  logic [NSYM-1:0][GW-1:0] pos;
  logic [GW-1:0]           code;
  logic [GW-1:0]           bus_q, bus_d;

  slc_pos_table #(.GW(GW), .RULE(RULE)) u_tab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (valid_i),
    .code_i (code),
    .pos_o  (pos)
  );

  // selection mux: the only logic ahead of the output register
  assign code = pos[sym_i];

  if (XOR_EN) begin : g_xor
    assign bus_d = bus_q ^ code;
  end else begin : g_plain
    assign bus_d = code;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bus_q <= '0;
    else if (valid_i) bus_q <= bus_d;
  end

  assign bus_o = bus_q;
endmodule

// File: rtl/slc_dec_group.sv
module slc_dec_group #(
  parameter int                 GW     = 2,
  parameter slc_pkg::slc_rule_e RULE   = slc_pkg::SLC_MTF,
  parameter bit                 XOR_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [GW-1:0] bus_i,
  output logic [GW-1:0] sym_o
);
  localparam int NSYM = 1 << GW;

  logic [NSYM-1:0][GW-1:0] pos;
  logic [GW-1:0]           code;
  logic [GW-1:0]           sym;
  logic [GW-1:0]           sym_q;

  if (XOR_EN) begin : g_xor
    logic [GW-1:0] prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      prev_q <= '0;
      else if (valid_i) prev_q <= bus_i;
    end
    assign code = bus_i ^ prev_q;
  end else begin : g_plain
    assign code = bus_i;
  end

  slc_pos_table #(.GW(GW), .RULE(RULE)) u_tab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (valid_i),
    .code_i (code),
    .pos_o  (pos)
  );

  // positions form a permutation, so exactly one symbol matches
  always_comb begin
    sym = '0;
    for (int s = 0; s < NSYM; s++) begin
      if (pos[s] == code) sym = GW'(s);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sym_q <= '0;
    else if (valid_i) sym_q <= sym;
  end

  assign sym_o = sym_q;
endmodule

// File: rtl/slc_addr_codec.sv
module slc_addr_codec #(
  parameter int                 ADDR_W = 32,
  parameter int                 GRP_W  = 2,
  parameter slc_pkg::slc_rule_e RULE   = slc_pkg::SLC_MTF,
  parameter bit                 XOR_EN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  input  logic [ADDR_W-1:0] enc_addr_i,
  output logic              enc_valid_o,
  output logic [ADDR_W-1:0] enc_bus_o,
  input  logic              dec_valid_i,
  input  logic [ADDR_W-1:0] dec_bus_i,
  output logic              dec_valid_o,
  output logic [ADDR_W-1:0] dec_addr_o
);
  localparam int NUM_GRP = ADDR_W / GRP_W;

  logic enc_vld_q, dec_vld_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    slc_enc_group #(.GW(GRP_W), .RULE(RULE), .XOR_EN(XOR_EN)) u_enc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (enc_valid_i),
      .sym_i   (enc_addr_i[g*GRP_W +: GRP_W]),
      .bus_o   (enc_bus_o[g*GRP_W +: GRP_W])
    );

    slc_dec_group #(.GW(GRP_W), .RULE(RULE), .XOR_EN(XOR_EN)) u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (dec_valid_i),
      .bus_i   (dec_bus_i[g*GRP_W +: GRP_W]),
      .sym_o   (dec_addr_o[g*GRP_W +: GRP_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_vld_q <= 1'b0;
      dec_vld_q <= 1'b0;
    end else begin
      enc_vld_q <= enc_valid_i;
      dec_vld_q <= dec_valid_i;
    end
  end

  assign enc_valid_o = enc_vld_q;
  assign dec_valid_o = dec_vld_q;
endmodule

// File: rtl/slc_addr_codec_chk.sv
module slc_addr_codec_chk #(
  parameter int                 ADDR_W = 32,
  parameter slc_pkg::slc_rule_e RULE   = slc_pkg::SLC_MTF,
  parameter bit                 XOR_EN = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enc_valid_i,
  input logic [ADDR_W-1:0] enc_addr_i,
  input logic              enc_valid_o,
  input logic [ADDR_W-1:0] enc_bus_o,
  input logic              dec_valid_i,
  input logic              dec_valid_o,
  input logic [ADDR_W-1:0] dec_addr_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R2
  enc_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);

  // R2
  enc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> !enc_valid_o);

  // R8
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> $stable(enc_bus_o));

  // R9
  dec_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> $stable(dec_addr_o));

  if (RULE == slc_pkg::SLC_MTF) begin : g_mtf
    // R3: a repeated address is already at the front, so its code is zero
    mtf_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && enc_valid_i && $past(enc_valid_i) && (enc_addr_i == $past(enc_addr_i)))
      |=> (XOR_EN ? $stable(enc_bus_o) : (enc_bus_o == '0)));
  end
endmodule

bind slc_addr_codec slc_addr_codec_chk #(
  .ADDR_W (ADDR_W),
  .RULE   (RULE),
  .XOR_EN (XOR_EN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enc_valid_i (enc_valid_i),
  .enc_addr_i  (enc_addr_i),
  .enc_valid_o (enc_valid_o),
  .enc_bus_o   (enc_bus_o),
  .dec_valid_i (dec_valid_i),
  .dec_valid_o (dec_valid_o),
  .dec_addr_o  (dec_addr_o)
);

// File: tb/slc_addr_codec_test.sv
`timescale 1ns/100ps
module slc_addr_codec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] addr = '0;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // instance 0: G=2 MTF plain, 1: G=2 transpose plain, 2: G=3 MTF xor, 3: G=4 transpose xor
  logic        ev0, ev1, ev2, ev3, dv0, dv1, dv2, dv3;
  logic [31:0] b0, b1, a0, a1;
  logic [11:0] b2, a2;
  logic [15:0] b3, a3;

  slc_addr_codec #(.ADDR_W(32), .GRP_W(2), .RULE(slc_pkg::SLC_MTF), .XOR_EN(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enc_valid_i(vld), .enc_addr_i(addr),
    .enc_valid_o(ev0), .enc_bus_o(b0), .dec_valid_i(ev0), .dec_bus_i(b0),
    .dec_valid_o(dv0), .dec_addr_o(a0));
  slc_addr_codec #(.ADDR_W(32), .GRP_W(2), .RULE(slc_pkg::SLC_TRANSPOSE), .XOR_EN(1'b0)) uut_tr (
    .clk_i(clk), .rst_ni(rst_n), .enc_valid_i(vld), .enc_addr_i(addr),
    .enc_valid_o(ev1), .enc_bus_o(b1), .dec_valid_i(ev1), .dec_bus_i(b1),
    .dec_valid_o(dv1), .dec_addr_o(a1));
  slc_addr_codec #(.ADDR_W(12), .GRP_W(3), .RULE(slc_pkg::SLC_MTF), .XOR_EN(1'b1)) uut_mx (
    .clk_i(clk), .rst_ni(rst_n), .enc_valid_i(vld), .enc_addr_i(addr[11:0]),
    .enc_valid_o(ev2), .enc_bus_o(b2), .dec_valid_i(ev2), .dec_bus_i(b2),
    .dec_valid_o(dv2), .dec_addr_o(a2));
  slc_addr_codec #(.ADDR_W(16), .GRP_W(4), .RULE(slc_pkg::SLC_TRANSPOSE), .XOR_EN(1'b1)) uut_tx (
    .clk_i(clk), .rst_ni(rst_n), .enc_valid_i(vld), .enc_addr_i(addr[15:0]),
    .enc_valid_o(ev3), .enc_bus_o(b3), .dec_valid_i(ev3), .dec_bus_i(b3),
    .dec_valid_o(dv3), .dec_addr_o(a3));

  // reference model: explicit ordered lists, searched per symbol
  int    gw[4] = '{2, 2, 3, 4};
  int    ng[4] = '{16, 16, 4, 4};
  int    rl[4] = '{0, 1, 0, 1};
  int    xe[4] = '{0, 0, 1, 1};
  string bus_tag[4] = '{"R3", "R4", "R7", "R7"};
  string dec_tag[4] = '{"R9", "R9", "R10", "R10"};
  string phase_tag = "";
  int    lst[4][16][16];
  logic [31:0] exp_bus[4], exp_addr[4], sent_a[4];
  logic        exp_ev[4], exp_dv[4];

  function automatic logic [31:0] wmask(int k);
    return (gw[k] * ng[k] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << (gw[k] * ng[k])) - 32'd1);
  endfunction

  function automatic void model_reset();
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < 16; g++)
        for (int p = 0; p < 16; p++) lst[k][g][p] = p;
      exp_bus[k] = '0; exp_addr[k] = '0; sent_a[k] = '0;
      exp_ev[k] = 1'b0; exp_dv[k] = 1'b0;
    end
  endfunction

  function automatic int model_send(int k, int g, int sym);
    int p = 0;
    for (int j = 0; j < (1 << gw[k]); j++) if (lst[k][g][j] == sym) p = j;
    if (rl[k] == 0) begin
      for (int j = p; j > 0; j--) lst[k][g][j] = lst[k][g][j-1];
      lst[k][g][0] = sym;
    end else if (p > 0) begin
      lst[k][g][p] = lst[k][g][p-1];
      lst[k][g][p-1] = sym;
    end
    return p;
  endfunction

  task automatic get_out(int k, output logic ev, output logic [31:0] bus,
                         output logic dv, output logic [31:0] ad);
    case (k)
      0: begin ev = ev0; bus = b0; dv = dv0; ad = a0; end
      1: begin ev = ev1; bus = b1; dv = dv1; ad = a1; end
      2: begin ev = ev2; bus = {20'd0, b2}; dv = dv2; ad = {20'd0, a2}; end
      default: begin ev = ev3; bus = {16'd0, b3}; dv = dv3; ad = {16'd0, a3}; end
    endcase
  endtask

  task automatic chk(string tag, string what, int k, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s inst%0d %s: got %h exp %h", tag, k, what, got, exp);
    end
  endtask

  task automatic check_all();
    logic ev, dv;
    logic [31:0] bus, ad;
    for (int k = 0; k < 4; k++) begin
      get_out(k, ev, bus, dv, ad);
      chk(phase_tag != "" ? phase_tag : "R2", "enc_valid", k, {31'd0, ev}, {31'd0, exp_ev[k]});
      chk(phase_tag != "" ? phase_tag : (exp_ev[k] ? bus_tag[k] : "R8"), "bus", k, bus, exp_bus[k]);
      chk(phase_tag != "" ? phase_tag : "R9", "dec_valid", k, {31'd0, dv}, {31'd0, exp_dv[k]});
      chk(phase_tag != "" ? phase_tag : dec_tag[k], "dec_addr", k, ad, exp_addr[k]);
    end
  endtask

  // one cycle: check, predict, drive, advance to next falling edge
  task automatic step(logic v, logic [31:0] a);
    check_all();
    for (int k = 0; k < 4; k++) begin
      logic [31:0] am = a & wmask(k);
      if (exp_ev[k]) exp_addr[k] = sent_a[k];
      exp_dv[k] = exp_ev[k];
      exp_ev[k] = v;
      if (v) begin
        logic [31:0] nb = '0;
        for (int g = 0; g < ng[k]; g++) begin
          int m = (1 << gw[k]) - 1;
          int sym = int'((am >> (g * gw[k]))) & m;
          int c = model_send(k, g, sym);
          int prev = int'((exp_bus[k] >> (g * gw[k]))) & m;
          int y = (xe[k] != 0) ? (prev ^ c) : c;
          nb = nb | (32'(y) << (g * gw[k]));
        end
        exp_bus[k] = nb;
        sent_a[k] = am;
      end
    end
    vld = v;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] rep2(int s);
    logic [31:0] r = '0;
    for (int g = 0; g < 16; g++) r = r | (32'(s & 3) << (2 * g));
    return r;
  endfunction

  int ex_in[9]  = '{0, 1, 0, 0, 2, 0, 1, 0, 3};
  int ex_mtf[9] = '{0, 1, 1, 0, 2, 1, 2, 1, 3};
  int ex_tr[9]  = '{0, 1, 1, 0, 2, 0, 2, 0, 3};

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    phase_tag = "R1";
    check_all();
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    phase_tag = "";

    // R5: the worked sequence on every group of the 2-bit instances
    for (int i = 0; i < 9; i++) begin
      step(1'b1, rep2(ex_in[i]));
      chk("R5", "mtf code", 0, {30'd0, b0[1:0]}, 32'(ex_mtf[i]));
      chk("R5", "transpose code", 1, {30'd0, b1[1:0]}, 32'(ex_tr[i]));
      chk("R5", "transpose code g15", 1, {30'd0, b1[31:30]}, 32'(ex_tr[i]));
    end

    // R8: idle cycles hold everything
    for (int i = 0; i < 4; i++) step(1'b0, $urandom);
    step(1'b1, 32'h0000_00FF);

    // R6: only the low groups move while the upper ones are fixed
    for (int i = 0; i < 24; i++) step(1'b1, {24'hA5C3_96, 8'(i * 37)});
    phase_tag = "R6";
    step(1'b1, 32'hA5C3_9600);
    phase_tag = "";

    // locality: two alternating address streams
    for (int i = 0; i < 40; i++)
      step(1'b1, (i % 2 == 0) ? 32'h1000_0000 + 32'(i * 4) : 32'h7FF0_0000 + 32'(i * 4));

    // R4 corner: repeats of a symbol already at the front
    for (int i = 0; i < 6; i++) step(1'b1, 32'h0000_0000);
    for (int i = 0; i < 6; i++) step(1'b1, 32'hFFFF_FFFF);

    // random traffic with gaps
    for (int i = 0; i < 600; i++) step(($urandom % 4) != 0, $urandom);

    // R1: reset in mid-run restores identity lists and clears outputs
    vld = 1'b0;
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    phase_tag = "R1";
    check_all();
    rst_n = 1'b1;
    phase_tag = "";
    for (int i = 0; i < 9; i++) begin
      step(1'b1, rep2(ex_in[i]));
      chk("R1", "mtf after reset", 0, {30'd0, b0[1:0]}, 32'(ex_mtf[i]));
    end
    for (int i = 0; i < 300; i++) step(($urandom % 3) != 0, $urandom);
    step(1'b0, '0);
    step(1'b0, '0);
    check_all();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule